// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block resolves PC-relative branches for a small processor with an 8-bit accumulator and a 16-bit program counter. For each branch request it takes a condition code, the four condition flags (negative N, zero Z, overflow V, carry C), a signed displacement and the sequential address, which is the address of the instruction after the branch. It reports whether the branch is taken and which program counter value comes next. The displacement is added to the sequential address. It is either a short 8-bit two's-complement value or a long 16-bit one.

The condition set has several groups. Single-flag tests check one flag set or clear. Signed-inequality tests combine Z, N and V. Unsigned-inequality tests combine Z and C. There is also an always-branch code and a never-branch code.

A companion flag generator adds two 8-bit operands and produces the sum with N, Z, V and C. A test environment can use it to derive flags from real arithmetic and feed them back into the branch inputs. Both paths are registered and have one cycle of latency.

Top module: `brc_top`

## Requirements
- R1: While `rst` is high at a clock edge, every output register is cleared: `res_valid`, `res_taken`, `res_pc`, `add_sum` and the four `add_*` flags are all 0.
- R2: `res_valid` is high exactly in the cycle after a cycle with `br_valid` high. After a cycle with `br_valid` low, `res_valid` is 0 and `res_taken` and `res_pc` keep their values.
- R3: A taken branch sets `res_pc` to `seq_pc` plus the sign-extended displacement, modulo 2^16. The offset is measured from the address after the branch, so `seq_pc` 0x020D with short displacement 0xF5 gives 0x0202.
- R4: With `br_long`=0 only `br_disp[7:0]` is used, sign-extended from bit 7. Bits 15:8 have no effect.
- R5: With `br_long`=1 all 16 bits of `br_disp` form the two's-complement displacement.
- R6: Single-flag codes are taken when their test is true. 4 takes on C=0, 5 on C=1, 6 on Z=0, 7 on Z=1, 8 on V=0, 9 on V=1, 10 on N=0 and 11 on N=1. Codes 4 and 5 also serve as unsigned higher-or-same and lower.
- R7: Signed codes are taken as follows. 12 (greater-or-equal) when N^V=0. 13 (less-than) when N^V=1. 14 (greater-than) when Z|(N^V)=0. 15 (less-or-equal) when Z|(N^V)=1.
- R8: Unsigned codes are taken as follows. 2 (higher) when C|Z=0. 3 (lower-or-same) when C|Z=1.
- R9: Code 0 is always taken and code 1 is never taken, whatever the flags are.
- R10: A branch that is not taken sets `res_pc` to `seq_pc`, whatever the displacement is.
- R11: One cycle after `add_a`/`add_b` are applied, `add_sum` holds their sum modulo 256. `add_n` equals bit 7 of that sum, and `add_z` is 1 exactly when the sum is 0.
- R12: `add_c` is 1 exactly when the unsigned sum exceeds 255.
- R13: `add_v` is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it. Operands of opposite sign never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch request strobe |
| br_cond | input | 4 | Condition code (see R6 to R9) |
| flag_n | input | 1 | Negative flag under test |
| flag_z | input | 1 | Zero flag under test |
| flag_v | input | 1 | Overflow flag under test |
| flag_c | input | 1 | Carry flag under test |
| br_long | input | 1 | 1 selects the 16-bit displacement, 0 the 8-bit one |
| br_disp | input | 16 | Displacement; only bits 7:0 are used in short form |
| seq_pc | input | 16 | Address of the instruction after the branch |
| add_a | input | 8 | Flag generator operand A |
| add_b | input | 8 | Flag generator operand B |
| res_valid | output | 1 | Branch result valid |
| res_taken | output | 1 | Branch taken |
| res_pc | output | 16 | Next program counter |
| add_sum | output | 8 | Registered sum |
| add_n | output | 1 | Sum negative |
| add_z | output | 1 | Sum zero |
| add_v | output | 1 | Signed overflow |
| add_c | output | 1 | Unsigned carry out |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data and an 8-bit short displacement. With these widths every condition code can be crossed with all sixteen flag combinations. The two sign-extension boundaries (0x7F/0x80 short and 0x7FFF/0x8000 long) and wrap-around at both ends of the 16-bit address space can also be reached with a handful of vectors. For the 8-bit adder, the extreme operand pairs that show each of carry, overflow and zero in isolation and together are equally easy to reach.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [3:0] {
    COND_ALWAYS = 4'd0,
    COND_NEVER  = 4'd1,
    COND_HI     = 4'd2,
    COND_LS     = 4'd3,
    COND_CC     = 4'd4,
    COND_CS     = 4'd5,
    COND_NE     = 4'd6,
    COND_EQ     = 4'd7,
    COND_VC     = 4'd8,
    COND_VS     = 4'd9,
    COND_PL     = 4'd10,
    COND_MI     = 4'd11,
    COND_GE     = 4'd12,
    COND_LT     = 4'd13,
    COND_GT     = 4'd14,
    COND_LE     = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/brc_flag_gen.sv
module brc_flag_gen #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] sum_q,
  output brc_pkg::flags_t   flags_q
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   wide_sum;
  brc_pkg::flags_t   flags_d;

  always_comb begin
    wide_sum   = {1'b0, op_a} + {1'b0, op_b};
    flags_d.n  = wide_sum[MSB];
    flags_d.z  = (wide_sum[MSB:0] == '0);
    flags_d.c  = wide_sum[DATA_W];
    flags_d.v  = (op_a[MSB] == op_b[MSB]) && (wide_sum[MSB] != op_a[MSB]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      flags_q <= '0;
    end else begin
      sum_q   <= wide_sum[MSB:0];
      flags_q <= flags_d;
    end
  end

  AST_V_MIXED_SIGN: assert property (@(posedge clk) disable iff (rst)
    (op_a[MSB] != op_b[MSB]) |=> !flags_q.v); // R13
  AST_Z_TRACKS_SUM: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flags_q.z == (sum_q == '0))); // R11
  AST_N_TRACKS_SUM: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flags_q.n == sum_q[MSB])); // R11

endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval (
  input  logic [3:0]      cond,
  input  brc_pkg::flags_t flags,
  output logic            take
);
  import brc_pkg::*;

  logic sgn_lt;
  logic sgn_le;
  logic uns_ls;

  always_comb begin
    sgn_lt = flags.n ^ flags.v;
    sgn_le = flags.z | sgn_lt;
    uns_ls = flags.c | flags.z;
    unique case (cond_e'(cond))
      COND_ALWAYS: take = 1'b1;
      COND_NEVER:  take = 1'b0;
      COND_HI:     take = !uns_ls;
      COND_LS:     take = uns_ls;
      COND_CC:     take = !flags.c;
      COND_CS:     take = flags.c;
      COND_NE:     take = !flags.z;
      COND_EQ:     take = flags.z;
      COND_VC:     take = !flags.v;
      COND_VS:     take = flags.v;
      COND_PL:     take = !flags.n;
      COND_MI:     take = flags.n;
      COND_GE:     take = !sgn_lt;
      COND_LT:     take = sgn_lt;
      COND_GT:     take = !sgn_le;
      COND_LE:     take = sgn_le;
      default:     take = 1'b0;
    endcase
  end

endmodule

// File: rtl/brc_target_calc.sv
module brc_target_calc #(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic [ADDR_W-1:0] base_pc,
  input  logic [ADDR_W-1:0] disp,
  input  logic              use_long,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] short_ext;
  logic [ADDR_W-1:0] offset;

  generate
    if (EXT_W > 0) begin : g_extend
      assign short_ext = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    end else begin : g_same
      assign short_ext = disp;
    end
  endgenerate

  always_comb begin
    offset = use_long ? disp : short_ext;
    target = base_pc + offset;
  end

endmodule

// File: rtl/brc_top.sv
module brc_top #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_valid,
  input  logic [3:0]        br_cond,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic              br_long,
  input  logic [ADDR_W-1:0] br_disp,
  input  logic [ADDR_W-1:0] seq_pc,
  input  logic [DATA_W-1:0] add_a,
  input  logic [DATA_W-1:0] add_b,
  output logic              res_valid,
  output logic              res_taken,
  output logic [ADDR_W-1:0] res_pc,
  output logic [DATA_W-1:0] add_sum,
  output logic              add_n,
  output logic              add_z,
  output logic              add_v,
  output logic              add_c
);
  import brc_pkg::*;

  flags_t            in_flags;
  flags_t            gen_flags;
  logic              take;
  logic [ADDR_W-1:0] target;

  assign in_flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

  brc_cond_eval u_cond (
    .cond  (br_cond),
    .flags (in_flags),
    .take  (take)
  );

  brc_target_calc #(
    .ADDR_W  (ADDR_W),
    .SHORT_W (SHORT_W)
  ) u_target (
    .base_pc  (seq_pc),
    .disp     (br_disp),
    .use_long (br_long),
    .target   (target)
  );

  brc_flag_gen #(
    .DATA_W (DATA_W)
  ) u_flags (
    .clk     (clk),
    .rst     (rst),
    .op_a    (add_a),
    .op_b    (add_b),
    .sum_q   (add_sum),
    .flags_q (gen_flags)
  );

  assign add_n = gen_flags.n;
  assign add_z = gen_flags.z;
  assign add_v = gen_flags.v;
  assign add_c = gen_flags.c;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_taken <= 1'b0;
      res_pc    <= '0;
    end else begin
      res_valid <= br_valid;
      if (br_valid) begin
        res_taken <= take;
        res_pc    <= take ? target : seq_pc;
      end
    end
  end

  AST_STROBE_TO_VALID: assert property (@(posedge clk) disable iff (rst)
    br_valid |=> res_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !br_valid |=> (!res_valid && $stable(res_pc) && $stable(res_taken))); // R2
  AST_NEVER_SEQ: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_cond == COND_NEVER) |=> (!res_taken && res_pc == $past(seq_pc))); // R10
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_cond == COND_ALWAYS) |=> res_taken); // R9

endmodule

// File: tb/brc_top_tb.sv
module brc_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        br_valid;
  logic [3:0]  br_cond;
  logic        flag_n, flag_z, flag_v, flag_c;
  logic        br_long;
  logic [15:0] br_disp;
  logic [15:0] seq_pc;
  logic [7:0]  add_a, add_b;
  logic        res_valid, res_taken;
  logic [15:0] res_pc;
  logic [7:0]  add_sum;
  logic        add_n, add_z, add_v, add_c;

  int checks = 0;
  int errors = 0;
  logic [16:0] exp_q[$];
  logic [15:0] last_pc;
  logic        last_taken;

  always #4 clk = ~clk;

  brc_top u_dut (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_cond(br_cond),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .br_long(br_long), .br_disp(br_disp), .seq_pc(seq_pc),
    .add_a(add_a), .add_b(add_b), .res_valid(res_valid), .res_taken(res_taken),
    .res_pc(res_pc), .add_sum(add_sum), .add_n(add_n), .add_z(add_z),
    .add_v(add_v), .add_c(add_c)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ref_take(input logic [3:0] c, input logic n, z, v, cy);
    case (c)
      4'd0: return 1;            // R9
      4'd1: return 0;            // R9
      4'd2: return !(cy || z);   // R8
      4'd3: return cy || z;      // R8
      4'd4: return !cy;          // R6
      4'd5: return cy;
      4'd6: return !z;
      4'd7: return z;
      4'd8: return !v;
      4'd9: return v;
      4'd10: return !n;
      4'd11: return n;
      4'd12: return (n == v);    // R7
      4'd13: return (n != v);
      4'd14: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  // driver: applies one branch request and pushes its expected result
  task automatic drive_branch(input logic [3:0] c, input logic [3:0] f, input logic lng,
                              input logic [15:0] d, input logic [15:0] pc);
    logic [15:0] off;
    logic        tk;
    off = lng ? d : {{8{d[7]}}, d[7:0]};     // R4 R5
    tk  = ref_take(c, f[3], f[2], f[1], f[0]);
    exp_q.push_back({tk, tk ? pc + off : pc}); // R3 R10
    @(posedge clk); #1;
    br_valid = 1'b1; br_cond = c;
    {flag_n, flag_z, flag_v, flag_c} = f;
    br_long = lng; br_disp = d; seq_pc = pc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      br_valid = 1'b0;
    end
  endtask

  // monitor: pops expected items as results appear
  initial begin
    logic [16:0] e;
    forever begin
      @(posedge clk); #4;
      if (!rst && res_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected result", {31'd0, res_valid}, 32'd0);
        end else begin
          e = exp_q.pop_front();
          check({res_taken, res_pc} == e, "R3-R10 branch result",
                {15'd0, res_taken, res_pc}, {15'd0, e});
          last_pc = res_pc; last_taken = res_taken;
        end
      end
    end
  end

  task automatic add_check(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] w;
    logic       ev;
    w  = {1'b0, a} + {1'b0, b};
    ev = (a[7] == b[7]) && (w[7] != a[7]);
    @(posedge clk); #1;
    add_a = a; add_b = b;
    @(posedge clk); #3;
    check(add_sum == w[7:0], "R11 sum", {24'd0, add_sum}, {24'd0, w[7:0]});
    check(add_n == w[7] && add_z == (w[7:0] == 8'd0), "R11 N/Z",
          {30'd0, add_n, add_z}, {30'd0, w[7], (w[7:0] == 8'd0)});
    check(add_c == w[8], "R12 carry", {31'd0, add_c}, {31'd0, w[8]});
    check(add_v == ev, "R13 overflow", {31'd0, add_v}, {31'd0, ev});
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; br_valid = 1'b0; br_cond = 4'd0;
    {flag_n, flag_z, flag_v, flag_c} = 4'h0;
    br_long = 1'b0; br_disp = 16'h1234; seq_pc = 16'hABCD;
    add_a = 8'h55; add_b = 8'h66;
    repeat (3) @(posedge clk);
    #3;
    // R1 reset state
    check(res_valid == 0 && res_taken == 0 && res_pc == 0, "R1 branch outputs",
          {15'd0, res_valid, res_pc}, 32'd0);
    check(add_sum == 0 && {add_n, add_z, add_v, add_c} == 0, "R1 adder outputs",
          {20'd0, add_sum, add_n, add_z, add_v, add_c}, 32'd0);
    @(posedge clk); #1; rst = 1'b0;

    // R3 worked example: 0x020D + (-0x0B) = 0x0202
    drive_branch(4'd0, 4'h0, 1'b0, 16'h00F5, 16'h020D);
    // R4 upper bits ignored in short form
    drive_branch(4'd0, 4'h0, 1'b0, 16'hA57F, 16'h1000);
    drive_branch(4'd0, 4'h0, 1'b0, 16'h3C80, 16'h1000);
    // R5 long form boundaries and wrap
    drive_branch(4'd0, 4'h0, 1'b1, 16'h7FFF, 16'h0001);
    drive_branch(4'd0, 4'h0, 1'b1, 16'h8000, 16'h0010);
    drive_branch(4'd0, 4'h0, 1'b0, 16'h0020, 16'hFFF0);
    // R10 not taken ignores displacement
    drive_branch(4'd1, 4'hF, 1'b1, 16'h4444, 16'h2222);
    // R6 R7 R8 R9 every code against every flag combination
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        drive_branch(c[3:0], f[3:0], f[0], {8'h0, 4'h9, f[3:0]} ^ {c[3:0], 12'h0}, 16'h4000 + 16'(c * 64));
    idle(1);
    @(posedge clk); #5;
    // R2 hold while idle
    seq_pc = 16'h7777; br_cond = 4'd0;
    @(posedge clk); #3;
    check(res_valid == 0 && res_pc == last_pc && res_taken == last_taken, "R2 idle hold",
          {15'd0, res_valid, res_pc}, {15'd0, 1'b0, last_pc});
    check(exp_q.size() == 0, "R2 all results returned", exp_q.size(), 32'd0);

    // R11 R12 R13 flag generator corners
    add_check(8'h7F, 8'h01);
    add_check(8'h80, 8'h80);
    add_check(8'h80, 8'h7F);
    add_check(8'hFF, 8'h01);
    add_check(8'h12, 8'h34);
    add_check(8'hC0, 8'hB0);

    // R7 flags from real subtraction: 5 - 9 signed gives LT taken, GE not taken
    add_check(8'h05, 8'hF7);
    drive_branch(4'd13, {add_n, add_z, add_v, add_c}, 1'b0, 16'h0004, 16'h0100);
    drive_branch(4'd12, {add_n, add_z, add_v, add_c}, 1'b0, 16'h0004, 16'h0100);
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule